// File: doc/BRIEF.md
# Cache-Line Split Access Sequencer

This block sits between an address-generation stage and a data cache. It accepts one memory operation at a time (a load, a store, or a zero-block store) with a byte address, a size code for 1, 2, 4 or 8 bytes, and the store operand. It then drives a single-outstanding request port toward the cache: a strobe, an address, a byte count, a write flag, a zero-block flag and eight byte lanes of write data. The strobe stays high until the cache answers with an acknowledge.

Most accesses produce one cache request. An access that is not aligned to its own size and also runs past the end of a cache line is issued as two requests. The first request covers the bytes from the original address up to the line end. After its acknowledge, the strobe is low for one cycle. The second request then covers the rest, starting at the base of the following line. Store operands are laid out big-endian across the lanes. For the second request the operand is moved up by the number of bytes already written, so the remaining low-order bytes land in the leading lanes. The line size is a parameter and must be a power of two of at least eight bytes.

Top module: `line_split_seq`

## Requirements
- R1: After reset, m_req and op_done are low and op_ready is high.
- R2: op_size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes, and m_size gives a byte count. An access that does not both sit off its natural alignment and run past a line end is issued as one request, with m_addr equal to op_addr and m_size equal to the full byte count.
- R3: The first request of a split access carries op_addr with m_size equal to the line size minus (op_addr mod line size).
- R4: The second request of a split access carries the base address of the next line (low offset bits zero) with m_size equal to the full byte count minus the first part's size.
- R5: An operation is accepted only while op_ready is high, and only one request is outstanding. m_req stays high until m_ack is seen. Between the two parts of a split access, m_req is low for exactly one cycle.
- R6: Store lanes are big-endian: m_data[63:56] is lane 0 and holds the most significant of the N operand bytes; lane i holds operand byte N-1-i. Lanes at or beyond N are zero.
- R7: On the second request of a split store, the lanes are packed from the operand shifted left by 8 × (first part's size) bits.
- R8: A zero-block operation (op_zero high) is never split. It is issued as one request at op_addr with the full size, m_zero and m_write high and m_data zero. Every other request has m_zero low.
- R9: A load request has m_write low, m_zero low and m_data zero.
- R10: op_done is high exactly in the cycle in which the last request of an operation is acknowledged. An acknowledge of the first part of a split access does not retire the operation. op_ready returns high in the following cycle.
- R11: m_ack is ignored while m_req is low, including the gap cycle of a split access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented |
| op_ready | output | 1 | Sequencer is idle and can accept an operation |
| op_write | input | 1 | Operation is a store |
| op_zero | input | 1 | Operation is a zero-block store |
| op_addr | input | ADDR_W | Byte address of the operation |
| op_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| op_wdata | input | 64 | Store operand, value in the low bits |
| op_done | output | 1 | Final acknowledge of the operation in this cycle |
| m_req | output | 1 | Cache request strobe |
| m_addr | output | ADDR_W | Cache request address |
| m_size | output | 4 | Cache request byte count |
| m_write | output | 1 | Cache request is a write |
| m_zero | output | 1 | Cache request zeroes a block |
| m_data | output | 64 | Write data, lane 0 in bits 63:56 |
| m_ack | input | 1 | Cache acknowledge |

## Verification
Two events can fall on the same clock edge: retiring an operation on its final acknowledge, and a new operation being presented. The bench raises op_valid with a second operation in exactly the cycle it acknowledges the last part. It then expects op_done high in that cycle, and the new operation not to be taken: m_req is low and op_ready is high one cycle later. It also drives m_ack during the one-cycle gap of a split access and expects the second part to appear unchanged. Random addresses near line ends, random sizes and random acknowledge delays are compared against bench-computed part addresses, sizes and lane images.

// File: rtl/lss_pkg.sv
package lss_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WHOLE = 2'd1,
      ST_HIGH  = 2'd2,
      ST_LOW   = 2'd3
   } lss_state_e;

endpackage

// File: rtl/lss_split_calc.sv
module lss_split_calc #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int MAX_BYTES  = 8,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int SZ_W   = $clog2(MAX_BYTES) + 1,
   localparam int CODE_W = $clog2($clog2(MAX_BYTES) + 1)
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              zero_i,
   output logic              split_o,
   output logic [SZ_W-1:0]   bytes_o,
   output logic [SZ_W-1:0]   first_o,
   output logic [SZ_W-1:0]   second_o,
   output logic [ADDR_W-1:0] next_addr_o
);

   logic [OFF_W-1:0] off;
   logic [SZ_W-1:0]  mask;
   logic [OFF_W:0]   to_end;
   logic             misaligned;
   logic             crosses;

   always_comb begin
      off        = addr_i[OFF_W-1:0];
      bytes_o    = SZ_W'(1) << code_i;
      mask       = bytes_o - SZ_W'(1);
      misaligned = |(addr_i[SZ_W-1:0] & mask);
      crosses    = (32'(off) + 32'(bytes_o)) > LINE_BYTES;
      split_o    = misaligned && crosses && !zero_i;
      to_end     = (OFF_W+1)'(LINE_BYTES) - {1'b0, off};
      first_o    = to_end[SZ_W-1:0];
      second_o   = bytes_o - first_o;
      next_addr_o = {addr_i[ADDR_W-1:OFF_W] + (ADDR_W-OFF_W)'(1), OFF_W'(0)};
   end

endmodule

// File: rtl/lss_lane_pack.sv
module lss_lane_pack #(
   parameter int MAX_BYTES = 8,
   localparam int DATA_W = 8 * MAX_BYTES,
   localparam int CODE_W = $clog2($clog2(MAX_BYTES) + 1)
) (
   input  logic              en_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [DATA_W-1:0] val_i,
   output logic [DATA_W-1:0] lanes_o
);

   for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
      logic [7:0] lane_b;
      always_comb begin
         int unsigned nb;
         nb     = 32'(1) << code_i;
         lane_b = '0;
         if (en_i && (i < nb))
            lane_b = 8'(val_i >> (8 * (nb - 1 - i)));
      end
      assign lanes_o[DATA_W-1-8*i -: 8] = lane_b;
   end

endmodule

// File: rtl/lss_ctrl.sv
module lss_ctrl
   import lss_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       split_i,
   input  logic       ack_i,
   output lss_state_e state_o,
   output logic       req_o,
   output logic       done_o,
   output logic       ready_o
);

   lss_state_e state_q;
   logic       gap_q;

   assign state_o = state_q;
   assign ready_o = (state_q == ST_IDLE);
   assign req_o   = (state_q != ST_IDLE) && !gap_q;
   assign done_o  = req_o && ack_i && ((state_q == ST_WHOLE) || (state_q == ST_LOW));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         gap_q   <= 1'b0;
      end else begin
         gap_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start_i) state_q <= split_i ? ST_HIGH : ST_WHOLE;
            ST_HIGH: if (req_o && ack_i) begin
               state_q <= ST_LOW;
               gap_q   <= 1'b1;
            end
            ST_WHOLE, ST_LOW: if (req_o && ack_i) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R5: strobe held until acknowledged
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> req_o);

   // R5: one low cycle after the first part, then the second part
   assert_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ack_i && state_q == ST_HIGH) |=> (!req_o && state_q == ST_LOW));

   assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ack_i && state_q == ST_HIGH) |=> ##1 req_o);

   // R11: acknowledge in the gap has no effect
   assert_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_o && ack_i && state_q == ST_LOW) |=> (state_q == ST_LOW && req_o));

   // R10: retire returns to idle
   assert_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (ready_o && !req_o));

endmodule

// File: rtl/line_split_seq.sv
module line_split_seq
   import lss_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int MAX_BYTES  = 8,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int SZ_W   = $clog2(MAX_BYTES) + 1,
   localparam int CODE_W = $clog2($clog2(MAX_BYTES) + 1),
   localparam int DATA_W = 8 * MAX_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   output logic              op_ready,
   input  logic              op_write,
   input  logic              op_zero,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [CODE_W-1:0] op_size,
   input  logic [DATA_W-1:0] op_wdata,
   output logic              op_done,
   output logic              m_req,
   output logic [ADDR_W-1:0] m_addr,
   output logic [SZ_W-1:0]   m_size,
   output logic              m_write,
   output logic              m_zero,
   output logic [DATA_W-1:0] m_data,
   input  logic              m_ack
);

   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line_pow2
      $error("LINE_BYTES must be a power of two");
   end
   if (LINE_BYTES < MAX_BYTES) begin : g_bad_line_small
      $error("LINE_BYTES must be at least MAX_BYTES");
   end
   if ((MAX_BYTES & (MAX_BYTES - 1)) != 0 || MAX_BYTES < 2) begin : g_bad_max
      $error("MAX_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   // operation split on entry
   logic              c_split;
   logic [SZ_W-1:0]   c_bytes, c_first, c_second;
   logic [ADDR_W-1:0] c_next;

   lss_split_calc #(
      .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)
   ) calc_i (
      .addr_i(op_addr), .code_i(op_size), .zero_i(op_zero),
      .split_o(c_split), .bytes_o(c_bytes), .first_o(c_first),
      .second_o(c_second), .next_addr_o(c_next)
   );

   lss_state_e st;
   logic       start;

   assign start = op_valid && op_ready;

   lss_ctrl ctrl_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .split_i(c_split),
      .ack_i(m_ack), .state_o(st), .req_o(m_req), .done_o(op_done),
      .ready_o(op_ready)
   );

   // captured operation
   logic [ADDR_W-1:0] addr_q, next_q;
   logic [SZ_W-1:0]   bytes_q, first_q, second_q;
   logic [CODE_W-1:0] code_q;
   logic              wr_q, zero_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= '0;
         next_q   <= '0;
         bytes_q  <= '0;
         first_q  <= '0;
         second_q <= '0;
         code_q   <= '0;
         wr_q     <= 1'b0;
         zero_q   <= 1'b0;
         data_q   <= '0;
      end else if (start) begin
         addr_q   <= op_addr;
         next_q   <= c_next;
         bytes_q  <= c_bytes;
         first_q  <= c_first;
         second_q <= c_second;
         code_q   <= op_size;
         wr_q     <= op_write || op_zero;
         zero_q   <= op_zero;
         data_q   <= op_wdata;
      end
   end

   // request fields by part
   logic [DATA_W-1:0] operand;
   logic              pack_en;

   always_comb begin
      m_addr  = (st == ST_LOW) ? next_q : addr_q;
      case (st)
         ST_HIGH: m_size = first_q;
         ST_LOW:  m_size = second_q;
         default: m_size = bytes_q;
      endcase
      m_write = wr_q;
      m_zero  = zero_q;
      pack_en = wr_q && !zero_q;
      operand = (st == ST_LOW) ? (data_q << {first_q, 3'b000}) : data_q;
   end

   lss_lane_pack #(.MAX_BYTES(MAX_BYTES)) pack_i (
      .en_i(pack_en), .code_i(code_q), .val_i(operand), .lanes_o(m_data)
   );

   // R4: second part starts on a line base
   assert_next_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && st == ST_LOW) |-> (m_addr[OFF_W-1:0] == '0));

   // R3: first part ends exactly at the line end
   assert_first_fit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && st == ST_HIGH) |-> ((32'(m_addr[OFF_W-1:0]) + 32'(m_size)) == LINE_BYTES));

   // R8: zero-block request is whole, a write, and carries no data
   assert_zero_whole_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && m_zero) |-> (m_write && m_data == '0 && st == ST_WHOLE));

   // R9: load request is quiet on write side
   assert_load_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_write) |-> (!m_zero && m_data == '0));

   // R5: no new capture while busy
   assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ack) |=> $stable(m_addr));

endmodule

// File: tb/line_split_seq_tb_top.sv
module line_split_seq_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int AW = 32;
   localparam int LB = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0, op_write = 1'b0, op_zero = 1'b0;
   logic [AW-1:0] op_addr = '0;
   logic [1:0]  op_size = '0;
   logic [63:0] op_wdata = '0;
   logic        op_ready, op_done, m_req, m_write, m_zero;
   logic        m_ack = 1'b0;
   logic [AW-1:0] m_addr;
   logic [3:0]  m_size;
   logic [63:0] m_data;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   line_split_seq dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_write(op_write), .op_zero(op_zero), .op_addr(op_addr),
      .op_size(op_size), .op_wdata(op_wdata), .op_done(op_done),
      .m_req(m_req), .m_addr(m_addr), .m_size(m_size), .m_write(m_write),
      .m_zero(m_zero), .m_data(m_data), .m_ack(m_ack)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] pack_be(input logic [63:0] v, input int nb);
      logic [63:0] r = '0;
      for (int i = 0; i < nb; i++) r[63-8*i -: 8] = 8'(v >> (8 * (nb - 1 - i)));
      return r;
   endfunction

   task automatic run_op(input logic [AW-1:0] addr, input int code, input bit wr,
                         input bit zr, input logic [63:0] data, input int dly,
                         input bit gap_ack, input bit early_next);
      int nb, off, first, parts;
      bit split;
      logic [AW-1:0] ea;
      int es;
      logic [63:0] ed;
      nb    = 1 << code;
      off   = int'(addr % LB);
      first = LB - off;
      split = !zr && ((addr % nb) != 0) && (off + nb > LB);
      parts = split ? 2 : 1;
      @(negedge clk);
      check(op_ready == 1'b1, "R5", "ready before op", 64'(op_ready), 64'd1);
      op_valid = 1'b1; op_write = wr; op_zero = zr; op_addr = addr;
      op_size = 2'(code); op_wdata = data;
      @(negedge clk);
      op_valid = 1'b0;
      for (int p = 0; p < parts; p++) begin
         if (!split) begin ea = addr; es = nb; end
         else if (p == 0) begin ea = addr; es = first; end
         else begin ea = addr - AW'(off) + AW'(LB); es = nb - first; end
         if (!wr || zr) ed = '0;
         else ed = pack_be((p == 1) ? (data << (8 * first)) : data, nb);
         for (int k = 0; k < dly; k++) begin
            check(m_req == 1'b1, "R5", "strobe held", 64'(m_req), 64'd1);
            @(negedge clk);
         end
         check(m_req == 1'b1, "R5", "strobe", 64'(m_req), 64'd1);
         check(m_addr == ea, split ? (p == 0 ? "R3" : "R4") : "R2", "addr", 64'(m_addr), 64'(ea));
         check(int'(m_size) == es, split ? (p == 0 ? "R3" : "R4") : "R2", "size", 64'(m_size), 64'(es));
         check(m_write == (wr | zr), wr ? "R8" : "R9", "write", 64'(m_write), 64'(wr | zr));
         check(m_zero == zr, "R8", "zero flag", 64'(m_zero), 64'(zr));
         check(m_data == ed, zr ? "R8" : (!wr ? "R9" : (p == 1 ? "R7" : "R6")), "lanes", m_data, ed);
         m_ack = 1'b1;
         if (p == parts - 1 && early_next) begin
            op_valid = 1'b1; op_write = 1'b0; op_zero = 1'b0; op_addr = addr + 32'd3;
         end
         #1;
         check(op_done == (p == parts - 1), "R10", "done on ack", 64'(op_done), 64'(p == parts - 1));
         @(negedge clk);
         m_ack = 1'b0; op_valid = 1'b0;
         if (p == 0 && split) begin
            check(m_req == 1'b0, "R5", "gap cycle", 64'(m_req), 64'd0);
            if (gap_ack) m_ack = 1'b1;
            @(negedge clk);
            m_ack = 1'b0;
            if (gap_ack) check(m_req == 1'b1, "R11", "gap ack ignored", 64'(m_req), 64'd1);
         end
      end
      check(m_req == 1'b0 && op_ready == 1'b1, early_next ? "R5" : "R10", "idle after retire",
            64'({m_req, op_ready}), 64'b01);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(m_req == 1'b0, "R1", "strobe after reset", 64'(m_req), 64'd0);
      check(op_ready == 1'b1, "R1", "ready after reset", 64'(op_ready), 64'd1);
      check(op_done == 1'b0, "R1", "done after reset", 64'(op_done), 64'd0);
      // R11 ack while idle
      m_ack = 1'b1;
      @(negedge clk);
      m_ack = 1'b0;
      check(m_req == 1'b0 && op_ready == 1'b1, "R11", "idle ack ignored",
            64'({m_req, op_ready}), 64'b01);
      // directed corners
      run_op(32'h1000_000F, 3, 1, 0, 64'h1122_3344_5566_7788, 0, 1, 0); // R7 first=1
      run_op(32'h1000_002C, 3, 1, 0, 64'h0102_0304_0506_0708, 2, 0, 1); // R3 R4 first=4
      run_op(32'h1000_0038, 3, 1, 0, 64'hA1A2_A3A4_A5A6_A7A8, 1, 0, 0); // R2 aligned at line end
      run_op(32'h2000_000F, 1, 1, 1, 64'hFFFF, 0, 0, 1);                 // R8 zero-block crossing
      run_op(32'h3000_001E, 2, 0, 0, 64'h0, 1, 1, 0);                    // R9 crossing load
      run_op(32'h3000_0005, 0, 1, 0, 64'h0000_0000_0000_00C3, 0, 0, 0);  // R6 single byte
      run_op(32'h3000_000D, 1, 1, 0, 64'h0000_0000_0000_BEEF, 0, 0, 0);  // R2 misaligned no cross
      run_op(32'h3000_001F, 1, 1, 0, 64'h0000_0000_0000_CAFE, 3, 1, 1);  // R7 halfword split
      for (int n = 0; n < 400; n++) begin
         logic [AW-1:0] a;
         int c;
         bit w, z;
         a = $urandom;
         if ($urandom_range(0, 1) == 1) a[3:0] = 4'(LB - $urandom_range(1, 8));
         c = $urandom_range(0, 3);
         w = ($urandom_range(0, 2) != 0);
         z = w && ($urandom_range(0, 7) == 0);
         run_op(a, c, w, z, {$urandom, $urandom}, $urandom_range(0, 3),
                bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule